// File: doc/BRIEF.md
# Countdown Timer with Latched Interrupt on a Single-Cycle Bus Port

This block is a one-register countdown timer reached through a classic cycle/strobe slave port. A bus write places a start value in the counter. After that the counter steps down toward zero at a pace set by a prescale parameter. A bus read returns the live count in the low bits of the read bus, with the upper bits cleared.

When the count arrives at zero, it stops there and the interrupt output rises. The interrupt stays high through idle time and through reads. Only the next write lowers it, and that write also starts a fresh countdown. The block has no address decoding, so every acknowledged access targets the one counter. It is meant for a simple delay: software writes a tick count, then waits for the interrupt.

Top module: `bus_countdown_timer`

## Requirements
- R1: After reset the interrupt is low and reads return zero. The interrupt stays low for as long as no write has taken place.
- R2: The acknowledge is high in exactly those cycles where both cycle and strobe are high, for reads and for writes. A write presented without both of them loads nothing.
- R3: An acknowledged write loads bits [CNT_W-1:0] of the write data at the clock edge that ends the write cycle. Higher data bits are discarded.
- R4: During an acknowledged read, the read bus carries the count in bits [CNT_W-1:0] and zeros above them, in the same cycle.
- R5: With PRESCALE = 0, the count drops by one on every clock edge after the load edge. One edge after the load edge it reads the loaded value minus one.
- R6: With PRESCALE = N > 0, the count drops by one once every N+1 clocks. The first drop comes N+1 edges after the load edge, because each write restarts the prescale phase.
- R7: Once the count is zero it holds at zero and never wraps.
- R8: The interrupt rises on the edge where the count becomes zero. A loaded value of zero raises it on the edge after the load edge.
- R9: Once high, the interrupt stays high across any number of idle and read cycles until a write.
- R10: A write clears the interrupt at its load edge and restarts the countdown. When that write lands on the same edge where the count would have reached zero, the write takes precedence: the new value is loaded and the interrupt stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_stb | input | 1 | Strobe for this slave |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data; low CNT_W bits become the start value |
| bus_rdata | output | 32 | Count, zero-extended, during a read |
| bus_ack | output | 1 | Same-cycle acknowledge |
| timer_irq | output | 1 | Latched expiry interrupt |

## Verification
The collision of interest is a load write and expiry arriving on the same clock edge. The bench writes 1 and, in the very next cycle, writes 4, so the second load meets the edge where the first countdown would end. The interrupt must read low after that edge and the count must read 4. A second collision is a write against an interrupt already latched; the bench judges it by checking that the interrupt is low one edge after the write. Two instances with different prescale values run on the same bus, so both pacing rules are judged against one model of elapsed edges.

// File: rtl/cdt_pkg.sv
// Package: shared bus width and the load request passed from the bus port
// to the counter. Assumes a fixed 32-bit data bus.
package cdt_pkg;
    localparam int BUS_W = 32;

    typedef struct packed {
        logic             valid;
        logic [BUS_W-1:0] data;
    } cdt_load_t;
endpackage

// File: rtl/cdt_prescaler.sv
// Prescaler: emits a one-cycle step pulse every PRESCALE+1 clocks.
// Assumes restart is a one-cycle pulse marking a load; the phase counter is
// cleared on it, and no pulse is emitted in that cycle.
module cdt_prescaler #(
    parameter int PRESCALE = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic step
);
    localparam int PW = (PRESCALE > 0) ? $clog2(PRESCALE + 1) : 1;

    generate
        if (PRESCALE == 0) begin : g_every_clock
            // Step on every clock that is not a load.
            assign step = !restart;
        end else begin : g_divided
            logic [PW-1:0] phase;
            logic          at_end;

            // Last phase of the divide window.
            assign at_end = (phase == PW'(PRESCALE));
            assign step   = at_end && !restart;

            // Phase counter: cleared by reset, by a load or at the window end.
            always_ff @(posedge clk) begin
                if (!rst_n || restart || at_end) begin
                    phase <= '0;
                end else begin
                    phase <= phase + PW'(1);
                end
            end

            // Two steps are never adjacent when dividing.
            assert_step_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
                step |=> !step);
        end
    endgenerate
endmodule

// File: rtl/cdt_down_counter.sv
// Down counter with latched interrupt. It loads on a valid load request,
// decrements on step while nonzero, and holds at zero. The interrupt may rise
// only after at least one load, so it stays low out of reset.
module cdt_down_counter
    import cdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cdt_load_t        load,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    logic [CNT_W-1:0] count_nxt;
    logic             irq_nxt;
    logic             armed;
    logic             armed_nxt;

    // Next-state: a load takes precedence over stepping and over expiry.
    always_comb begin
        count_nxt = count;
        irq_nxt   = irq;
        armed_nxt = armed;
        if (load.valid) begin
            count_nxt = load.data[CNT_W-1:0];
            irq_nxt   = 1'b0;
            armed_nxt = 1'b1;
        end else begin
            if (step && (count != '0)) begin
                count_nxt = count - CNT_W'(1);
            end
            if (armed && (count_nxt == '0)) begin
                irq_nxt = 1'b1;
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            irq   <= 1'b0;
            armed <= 1'b0;
        end else begin
            count <= count_nxt;
            irq   <= irq_nxt;
            armed <= armed_nxt;
        end
    end

    assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load.valid |=> (count == $past(load.data[CNT_W-1:0])));
    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load.valid |=> ((count == $past(count)) || (count == $past(count) - CNT_W'(1))));
    assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load.valid && (count == '0)) |=> (count == '0));
    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !load.valid) |=> irq);
    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load.valid |=> !irq);
endmodule

// File: rtl/cdt_bus_port.sv
// Bus port: same-cycle acknowledge, load request generation and read data.
// Assumes one register, so no address decode; reads have no side effects.
module cdt_bus_port
    import cdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             bus_cyc,
    input  logic             bus_stb,
    input  logic             bus_we,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0] count,
    output logic             bus_ack,
    output cdt_load_t        load,
    output logic [BUS_W-1:0] bus_rdata
);
    logic sel;

    // Decode the access and zero-extend the count for reads.
    always_comb begin
        sel        = bus_cyc && bus_stb;
        bus_ack    = sel;
        load.valid = sel && bus_we;
        load.data  = bus_wdata;
        bus_rdata  = '0;
        if (sel && !bus_we) begin
            bus_rdata[CNT_W-1:0] = count;
        end
    end
endmodule

// File: rtl/bus_countdown_timer.sv
// Top: countdown timer with latched interrupt on a cycle/strobe bus port.
// Assumes the clock is free running and the reset is synchronous, active low.
module bus_countdown_timer
    import cdt_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int PRESCALE = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_cyc,
    input  logic        bus_stb,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ack,
    output logic        timer_irq
);
    cdt_load_t        load;
    logic             step;
    logic [CNT_W-1:0] count;

    cdt_bus_port #(.CNT_W(CNT_W)) u_port (
        .bus_cyc  (bus_cyc),
        .bus_stb  (bus_stb),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .count    (count),
        .bus_ack  (bus_ack),
        .load     (load),
        .bus_rdata(bus_rdata)
    );

    cdt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(load.valid),
        .step   (step)
    );

    cdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .step (step),
        .count(count),
        .irq  (timer_irq)
    );

    assert_read_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !bus_we) |-> ((bus_rdata >> CNT_W) == '0));
    assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_stb && bus_we) |=> !timer_irq);
endmodule

// File: tb/test_bus_countdown_timer.sv
`timescale 1ns/1ps
// Scoreboard bench: two instances (prescale 0 and 2) share one bus. The read
// driver pushes expected counts; a monitor pops and compares on each read.
module test_bus_countdown_timer;
    localparam int CW = 8;
    localparam int N2 = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd0, rd2;
    logic        ack0, ack2, irq0, irq2;

    int    tests = 0, fails = 0;
    int    cyc_n = 0;
    int    load_at = 0, load_val = 0;
    bit    loaded = 0;
    bit    done = 0;
    int    exp0_q[$], exp2_q[$];
    string tag_q[$];

    bus_countdown_timer #(.CNT_W(CW), .PRESCALE(0)) i_bus_countdown_timer (
        .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rd0),
        .bus_ack(ack0), .timer_irq(irq0));

    bus_countdown_timer #(.CNT_W(CW), .PRESCALE(N2)) i_bus_countdown_timer_p2 (
        .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rd2),
        .bus_ack(ack2), .timer_irq(irq2));

    always #10 clk = ~clk;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    function automatic int exp_cnt(int n);
        int d;
        if (!loaded) return 0;
        d = (cyc_n - load_at) / (n + 1);
        return (d >= load_val) ? 0 : load_val - d;
    endfunction

    function automatic bit exp_irq(int n);
        return loaded && ((cyc_n - load_at) >= 1) && (exp_cnt(n) == 0);
    endfunction

    task automatic check(string tag, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic bus_idle(int n);
        repeat (n) begin
            @(negedge clk);
            bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
        end
        #1;
    endtask

    // Drive a write for one cycle; leaves the bus driven.
    task automatic do_write(logic [31:0] v);
        @(negedge clk);
        bus_wdata = v; bus_we = 1'b1; bus_cyc = 1'b1; bus_stb = 1'b1;
        #1;
        check("R2 write ack", {ack0, ack2}, 2'b11);
        load_at  = cyc_n + 1;
        load_val = int'(v[CW-1:0]);
        loaded   = 1;
    endtask

    // Drive a read for one cycle and push the expected results.
    task automatic do_read(string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_cyc = 1'b1; bus_stb = 1'b1;
        #1;
        check("R2 read ack", {ack0, ack2}, 2'b11);
        exp0_q.push_back(exp_cnt(0));
        exp2_q.push_back(exp_cnt(N2));
        tag_q.push_back(tag);
    endtask

    task automatic check_irq(string tag);
        check({tag, " irq p0"}, int'(irq0), int'(exp_irq(0)));
        check({tag, " irq p2"}, int'(irq2), int'(exp_irq(N2)));
    endtask

    // Monitor: pops the scoreboard on every acknowledged read.
    always begin
        @(negedge clk);
        #2;
        if (bus_cyc && bus_stb && !bus_we) begin
            if (tag_q.size() == 0) begin
                check("scoreboard underflow", 1, 0);
            end else begin
                string t;
                t = tag_q.pop_front();
                check({t, " R4 count p0"}, int'(rd0), exp0_q.pop_front());
                check({t, " R4 count p2"}, int'(rd2), exp2_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        bus_idle(4);
        check_irq("R1 after reset");
        do_read("R1 reset count");
        bus_idle(1);

        // R2: incomplete handshakes give no ack and load nothing.
        @(negedge clk);
        bus_wdata = 32'd9; bus_we = 1'b1; bus_cyc = 1'b0; bus_stb = 1'b1;
        #1 check("R2 stb only ack", {ack0, ack2}, 2'b00);
        @(negedge clk);
        bus_cyc = 1'b1; bus_stb = 1'b0;
        #1 check("R2 cyc only ack", {ack0, ack2}, 2'b00);
        bus_idle(1);
        check_irq("R2 no load");
        do_read("R2 no load");

        // R3/R5/R6: load and follow the countdown every cycle.
        do_write(32'd5);
        bus_idle(1);
        check_irq("R10 after load");
        for (int i = 0; i < 8; i++) do_read("R5 R6 countdown");
        bus_idle(1);
        check_irq("R8 p0 expired");

        // R7/R9: long idle and repeated reads keep zero and the interrupt.
        bus_idle(25);
        check_irq("R9 idle");
        do_read("R7 hold zero");
        do_read("R7 hold zero");
        bus_idle(3);
        check_irq("R9 after reads");

        // R3/R10: truncating write clears the interrupt at once.
        do_write(32'h1234_5603);
        bus_idle(1);
        check_irq("R10 clear");
        do_read("R3 truncation");

        // R8: loading zero raises the interrupt one edge later.
        do_write(32'd0);
        bus_idle(1);
        check_irq("R8 zero load edge");
        bus_idle(1);
        check_irq("R8 zero load next");
        check("R8 zero load p0 irq", int'(irq0), 1);

        // R10: second write lands on the expiry edge of the first.
        do_write(32'd1);
        do_write(32'd4);
        bus_idle(1);
        check("R10 collision irq", int'(irq0), 0);
        check_irq("R10 collision");
        do_read("R10 collision count");

        // R6: a rewrite mid-window restarts the prescale phase.
        do_write(32'd6);
        bus_idle(2);
        do_write(32'd6);
        bus_idle(1);
        for (int i = 0; i < 7; i++) do_read("R6 restart");
        bus_idle(30);
        check_irq("R7 R8 final");
        do_read("R7 final");
        bus_idle(2);
        finish_run();
    end
endmodule